// File: doc/BRIEF.md
# Multi-Bank Converter Acquisition Sequencer

This block runs periodic acquisition frames across up to four converter chips of eight channels each. A host programs it over a small 16-bit register bus. When the programmed period expires, every selected chip gets a start pulse at the same time. The sequencer waits until each started chip reports done. It then walks the captured results in a fixed order and writes only the channels that the shared mask enables into a single sample FIFO. The host drains that FIFO through a data register.

The status register reports the FIFO fill level and a sticky overflow flag. An interrupt output can follow the fill level against a threshold, either as a level or as a single-cycle pulse on the upward crossing. Two standby outputs are available. One holds the chips asleep and blocks new frames. The other puts the chips to sleep between frames.

Top module: `adc_seq_top`

## Requirements
- R1: Word address 0 of the bus reads the constant 0xADC1, and after reset the status word (address 2) reads 0.
- R2: The control word (address 1), period low and high halves (addresses 4 and 5) and IRQ threshold (address 6) read back what was last written. Control bits are: 15:8 channel mask, 7:6 highest chip index, 5 hold-asleep, 4 sleep-between-frames, 3 edge IRQ mode, 2 IRQ enable, 1 run, 0 wipe.
- R3: A frame writes results chip by chip from chip 0 up to the highest chip index, channels 0 to 7 within each chip. Only channels whose mask bit is 1 are written.
- R4: The mask applies to every chip. With only channel k enabled and highest index 1, the FIFO alternates chip 0 channel k, then chip 1 channel k.
- R5: While run is 1 and the block is idle, frames begin every P clock cycles, where P is the 32-bit period. A period of 0 behaves as 1.
- R6: Reading address 3 returns the oldest FIFO entry and removes it. Status bits 14:0 give the number of stored entries.
- R7: Results that arrive while the FIFO is full are dropped. Status bit 15 is then set, and it stays set across reads until a wipe.
- R8: While the wipe bit is 1, the FIFO is empty, the overflow flag is clear, and the chip reset output is high.
- R9: With IRQ enabled and edge mode off, the irq output is high exactly when the entry count is at or above the threshold.
- R10: With IRQ enabled in edge mode, irq pulses for one cycle when the count rises from below to at or above the threshold.
- R11: With hold-asleep set, no start pulse is issued and every standby output is high while the block is idle.
- R12: With sleep-between-frames set, standby is high while the block is idle and low from the start pulse until the frame's last write.
- R13: Clearing run stops new frames. A frame already started still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the FIFO at address 3) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Fill-threshold interrupt |
| conv_rst | output | 1 | Reset to the converter chips |
| conv_start | output | NCHIP | One-cycle start pulse per chip |
| conv_standby | output | NCHIP | Standby request per chip |
| conv_done | input | NCHIP | Per-chip conversion complete, data valid |
| conv_data | input | NCHIP*128 | Eight 16-bit results per chip, channel 0 in the low bits |

## Verification
The bench builds random chip counts and masks, then rebuilds the expected stream from its own chip model. A design that got the chip and channel loop order backwards, or that used the mask per chip, would put words in the wrong places. The overflow case fills the FIFO until it drops data. A design without a sticky flag would lose bit 15 once the FIFO was drained, and a design that overwrote old data would return later frames. The two IRQ modes are checked against the fill level that was just read: a level-only design shows more than one pulse in edge mode, and an off-by-one compare gives a wrong level at the threshold. The period, stop and hold-asleep cases count start pulses, so stray or late frames show up directly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_PER_CHIP = 8;
    localparam int SMP_W       = 16;
    localparam logic [15:0] CORE_ID = 16'hADC1;

    typedef enum logic [2:0] {
        REG_ID   = 3'd0,
        REG_CTRL = 3'd1,
        REG_STAT = 3'd2,
        REG_DATA = 3'd3,
        REG_PLO  = 3'd4,
        REG_PHI  = 3'd5,
        REG_THR  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic [CH_PER_CHIP-1:0] mask;
        logic [1:0]             top_chip;
        logic                   hold_sleep;
        logic                   idle_sleep;
        logic                   irq_edge;
        logic                   irq_on;
        logic                   run;
        logic                   wipe;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRAIN = 2'd2
    } eng_state_e;

    function automatic int clamp_top(input logic [1:0] top, input int nchip);
        return (int'(top) > nchip - 1) ? nchip - 1 : int'(top);
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] period,
    output logic        tick
);
    logic [31:0] cnt_q;
    logic        last;

    always_comb begin
        last = (period <= 32'd1) || (cnt_q >= period - 32'd1);
        tick = en && last;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 32'd1;
    end
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          pop_ok, wr_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        pop_ok = pop && (count != '0);
        wr_ok  = push && ((count < CW'(DEPTH)) || pop_ok);
        rdata  = mem_q[rd_q];
    end

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem_q[wr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr_ok)  wr_q <= bump(wr_q);
            if (pop_ok) rd_q <= bump(rd_q);
            count <= count + CW'(wr_ok) - CW'(pop_ok);
            if (push && !wr_ok)
                ovf <= 1'b1;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);                                     // R7
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));                                       // R7
    AST_WIPE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && !ovf));                             // R8
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [15:0] fifo_rdata,
    input  logic [14:0] fifo_count,
    input  logic        fifo_ovf,
    output logic        fifo_pop,
    output ctrl_t       ctrl,
    output logic [31:0] period,
    output logic        irq
);
    reg_sel_e    sel;
    logic [15:0] thr_q;
    logic        at_lvl, at_q;

    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            period <= '0;
            thr_q  <= '0;
            at_q   <= 1'b0;
        end else begin
            at_q <= at_lvl;
            if (bus_wr) begin
                case (sel)
                    REG_CTRL: ctrl          <= ctrl_t'(bus_wdata);
                    REG_PLO:  period[15:0]  <= bus_wdata;
                    REG_PHI:  period[31:16] <= bus_wdata;
                    REG_THR:  thr_q         <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        fifo_pop = bus_rd && (sel == REG_DATA);
        case (sel)
            REG_ID:   bus_rdata = CORE_ID;
            REG_CTRL: bus_rdata = ctrl;
            REG_STAT: bus_rdata = {fifo_ovf, fifo_count};
            REG_DATA: bus_rdata = fifo_rdata;
            REG_PLO:  bus_rdata = period[15:0];
            REG_PHI:  bus_rdata = period[31:16];
            REG_THR:  bus_rdata = thr_q;
            default:  bus_rdata = '0;
        endcase
        at_lvl = {1'b0, fifo_count} >= thr_q;
        if (!ctrl.irq_on)
            irq = 1'b0;
        else if (ctrl.irq_edge)
            irq = at_lvl && !at_q;
        else
            irq = at_lvl;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (irq && ctrl.irq_edge && !bus_wr) |=> !irq);                // R10
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
    import adc_seq_pkg::*;
#(
    parameter int NCHIP = 4,
    parameter int DW    = SMP_W,
    localparam int CIW  = (NCHIP > 1) ? $clog2(NCHIP) : 1,
    localparam int CHW  = $clog2(CH_PER_CHIP),
    localparam int ROWW = CH_PER_CHIP * DW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  ctrl_t                 ctrl,
    input  logic [NCHIP-1:0]      conv_done,
    input  logic [NCHIP*ROWW-1:0] conv_data,
    output logic [NCHIP-1:0]      conv_start,
    output logic                  busy,
    output logic                  push,
    output logic [DW-1:0]         push_data
);
    eng_state_e              st_q;
    logic [CIW-1:0]          top_q, chip_q, top_eff;
    logic [CHW-1:0]          ch_q;
    logic [CH_PER_CHIP-1:0]  mask_q;
    logic [NCHIP-1:0]        sel_q, seen_q, start_q, sel_now;
    logic [NCHIP-1:0][ROWW-1:0] rows;
    logic                    launch, last_slot;

    always_comb begin
        top_eff = CIW'(clamp_top(ctrl.top_chip, NCHIP));
        for (int i = 0; i < NCHIP; i++)
            sel_now[i] = (i <= int'(top_eff));
        launch    = (st_q == ST_IDLE) && tick && ctrl.run && !ctrl.hold_sleep;
        last_slot = (chip_q == top_q) && (ch_q == CHW'(CH_PER_CHIP - 1));
        busy      = (st_q != ST_IDLE);
        push      = (st_q == ST_DRAIN) && mask_q[ch_q];
        push_data = rows[chip_q][ch_q*DW +: DW];
    end

    assign conv_start = start_q;

    for (genvar c = 0; c < NCHIP; c++) begin : g_chip
        logic [ROWW-1:0] row_q;
        always_ff @(posedge clk) begin
            if (st_q == ST_WAIT && sel_q[c] && conv_done[c] && !seen_q[c])
                row_q <= conv_data[c*ROWW +: ROWW];
        end
        assign rows[c] = row_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            start_q <= '0;
            sel_q   <= '0;
            seen_q  <= '0;
            top_q   <= '0;
            chip_q  <= '0;
            ch_q    <= '0;
            mask_q  <= '0;
        end else begin
            start_q <= '0;
            case (st_q)
                ST_IDLE: begin
                    if (launch) begin
                        st_q    <= ST_WAIT;
                        start_q <= sel_now;
                        sel_q   <= sel_now;
                        seen_q  <= '0;
                        top_q   <= top_eff;
                        mask_q  <= ctrl.mask;
                    end
                end
                ST_WAIT: begin
                    seen_q <= seen_q | (conv_done & sel_q);
                    if (seen_q == sel_q) begin
                        st_q   <= ST_DRAIN;
                        chip_q <= '0;
                        ch_q   <= '0;
                    end
                end
                ST_DRAIN: begin
                    if (last_slot) begin
                        st_q <= ST_IDLE;
                    end else if (ch_q == CHW'(CH_PER_CHIP - 1)) begin
                        ch_q   <= '0;
                        chip_q <= chip_q + CIW'(1);
                    end else begin
                        ch_q <= ch_q + CHW'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (|conv_start) |-> $past(ctrl.run));                         // R13
    AST_START_NOT_HELD: assert property (@(posedge clk) disable iff (rst)
        (|conv_start) |-> !$past(ctrl.hold_sleep));                 // R11
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int NCHIP      = 4,
    parameter int FIFO_DEPTH = 64,
    localparam int ROWW      = CH_PER_CHIP * SMP_W,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    output logic                  irq,
    output logic                  conv_rst,
    output logic [NCHIP-1:0]      conv_start,
    output logic [NCHIP-1:0]      conv_standby,
    input  logic [NCHIP-1:0]      conv_done,
    input  logic [NCHIP*ROWW-1:0] conv_data
);
    ctrl_t             ctrl;
    logic [31:0]       period;
    logic              tick, busy, push, pop, ovf, clr;
    logic [SMP_W-1:0]  push_data, fifo_rdata;
    logic [CW-1:0]     count;

    assign clr      = rst || ctrl.wipe;
    assign conv_rst = ctrl.wipe;

    adc_seq_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_rdata(fifo_rdata), .fifo_count(15'(count)), .fifo_ovf(ovf),
        .fifo_pop(pop), .ctrl(ctrl), .period(period), .irq(irq)
    );

    adc_seq_timer u_timer (
        .clk(clk), .rst(rst), .en(ctrl.run && !ctrl.wipe),
        .period(period), .tick(tick)
    );

    adc_seq_engine #(.NCHIP(NCHIP), .DW(SMP_W)) u_eng (
        .clk(clk), .rst(clr), .tick(tick), .ctrl(ctrl),
        .conv_done(conv_done), .conv_data(conv_data),
        .conv_start(conv_start), .busy(busy),
        .push(push), .push_data(push_data)
    );

    adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .DW(SMP_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(clr),
        .push(push), .wdata(push_data), .pop(pop),
        .rdata(fifo_rdata), .count(count), .ovf(ovf)
    );

    for (genvar c = 0; c < NCHIP; c++) begin : g_sb
        assign conv_standby[c] = !busy && (ctrl.hold_sleep || ctrl.idle_sleep);
    end

    AST_AWAKE_ON_START: assert property (@(posedge clk) disable iff (rst)
        (|conv_start) |-> (conv_standby == '0));                    // R12
endmodule

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
    logic clk = 1'b0, rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic irq, conv_rst;
    logic [3:0] conv_start, conv_standby;
    logic [3:0] conv_done = '0;
    logic [511:0] conv_data = '0;

    int checks = 0, errors = 0, cyc = 0, starts = 0;
    int last_start = 0, prev_start = 0, irq_hits = 0, sb_bad = 0;
    bit cnt_irq = 0, fin = 0;
    int mframe[4], mtimer[4];

    always #5 clk = ~clk;

    adc_seq_top u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .conv_rst(conv_rst), .conv_start(conv_start),
        .conv_standby(conv_standby), .conv_done(conv_done), .conv_data(conv_data)
    );

    function automatic logic [15:0] ev(input int c, input int ch, input int f);
        logic [31:0] cc = c, hh = ch, ff = f;
        return {cc[1:0], hh[2:0], ff[10:0]};
    endfunction

    function automatic logic [15:0] mkc(input logic [7:0] m, input int top,
        input bit hold, input bit sb, input bit edg, input bit ien, input bit run, input bit wipe);
        logic [31:0] t = top;
        return {m, t[1:0], hold, sb, edg, ien, run, wipe};
    endfunction

    // converter chip model and monitors, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (conv_start[0]) begin starts++; prev_start = last_start; last_start = cyc; end
        if (|conv_start && conv_standby != 4'h0) sb_bad++;
        if (cnt_irq && irq) irq_hits++;
        for (int c = 0; c < 4; c++) begin
            if (conv_rst) begin
                mframe[c] = 0; mtimer[c] = 0; conv_done[c] = 1'b0;
            end else begin
                conv_done[c] = 1'b0;
                if (mtimer[c] > 0) begin
                    mtimer[c]--;
                    if (mtimer[c] == 0) conv_done[c] = 1'b1;
                end
                if (conv_start[c]) begin
                    mtimer[c] = 3;
                    for (int k = 0; k < 8; k++)
                        conv_data[(c*8+k)*16 +: 16] = ev(c, k, mframe[c]);
                    mframe[c]++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [15:0] d);
        @(negedge clk); bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [15:0] d);
        @(negedge clk); bus_addr = 3'(a); bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prep();
        bus_write(1, mkc(8'h00, 0, 0, 0, 0, 0, 0, 1));
        #1 chk(conv_rst == 1'b1, "R8 chip reset", conv_rst, 1);
        bus_write(1, 16'h0000);
    endtask

    task automatic set_period(input logic [31:0] p);
        bus_write(4, p[15:0]);
        bus_write(5, p[31:16]);
    endtask

    task automatic wait_count(input int target, output int got);
        logic [15:0] s;
        got = 0;
        for (int i = 0; i < 4000; i++) begin
            bus_read(2, s);
            got = int'(s[14:0]);
            if (got >= target) break;
        end
    endtask

    task automatic check_stream(input int hi, input logic [7:0] m, input int n, input string req);
        int f = 0, c = 0, ch = 0, bad = 0;
        logic [15:0] got, exp;
        for (int i = 0; i < n; i++) begin
            while (!m[ch]) begin
                ch++; if (ch == 8) begin ch = 0; c++; if (c > hi) begin c = 0; f++; end end
            end
            exp = ev(c, ch, f);
            bus_read(3, got);
            if (got != exp && bad == 0) chk(0, req, got, exp);
            if (got != exp) bad++;
            ch++; if (ch == 8) begin ch = 0; c++; if (c > hi) begin c = 0; f++; end end
        end
        if (bad == 0) chk(1, req, 0, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!fin) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int n, per, hi, pc, s0, mism;
        logic [7:0] m;
        void'($urandom(32'd7731));
        idle(4);
        @(negedge clk); rst = 1'b0;
        idle(2);

        // R1: identity and reset state
        bus_read(0, d); chk(d == 16'hADC1, "R1 id", d, 16'hADC1);
        bus_read(2, d); chk(d == 16'h0, "R1 status at reset", d, 0);
        chk(irq == 1'b0 && conv_start == 4'h0, "R1 outputs at reset", {irq, conv_start}, 0);

        // R2: register read-back
        bus_write(4, 16'h1234); bus_write(5, 16'hABCD); bus_write(6, 16'h0007);
        bus_write(1, 16'hA5C0);
        bus_read(4, d); chk(d == 16'h1234, "R2 period lo", d, 16'h1234);
        bus_read(5, d); chk(d == 16'hABCD, "R2 period hi", d, 16'hABCD);
        bus_read(6, d); chk(d == 16'h0007, "R2 threshold", d, 7);
        bus_read(1, d); chk(d == 16'hA5C0, "R2 control", d, 16'hA5C0);

        // R4: single channel, two chips alternate
        prep(); set_period(32'd60);
        bus_write(1, mkc(8'h04, 1, 0, 0, 0, 0, 1, 0));
        wait_count(6, n);
        bus_write(1, mkc(8'h04, 1, 0, 0, 0, 0, 0, 0));
        idle(80);
        bus_read(2, d); n = int'(d[14:0]);
        chk(n >= 6 && n % 2 == 0, "R4 count", n, 6);
        check_stream(1, 8'h04, n, "R4 alternate order");
        bus_read(2, d); chk(d == 16'h0, "R6 drained", d, 0);

        // R3 / R6: random chip counts and masks
        for (int it = 0; it < 5; it++) begin
            hi = int'($urandom % 4);
            m  = 8'($urandom % 255 + 1);
            pc = 0; for (int b = 0; b < 8; b++) pc += m[b];
            per = pc * (hi + 1);
            prep(); set_period(32'(60 + $urandom % 60));
            bus_write(1, mkc(m, hi, 0, 0, 0, 0, 1, 0));
            wait_count(per, n);
            bus_write(1, mkc(m, hi, 0, 0, 0, 0, 0, 0));
            idle(80);
            bus_read(2, d); n = int'(d[14:0]);
            chk(d[15] == 1'b0 && n >= per && n % per == 0 && n <= 64, "R6 status count", d, per);
            check_stream(hi, m, n, "R3 frame order");
        end

        // R5 period and R13 stop
        prep(); set_period(32'd100);
        bus_write(1, mkc(8'h01, 0, 0, 0, 0, 0, 1, 0));
        s0 = starts;
        for (int i = 0; i < 1000 && starts < s0 + 3; i++) @(negedge clk);
        chk(last_start - prev_start == 100, "R5 period spacing", last_start - prev_start, 100);
        bus_write(1, mkc(8'h01, 0, 0, 0, 0, 0, 0, 0));
        idle(20); s0 = starts; idle(300);
        chk(starts == s0, "R13 no frames after stop", starts - s0, 0);

        // R7 overflow and R8 wipe
        prep(); set_period(32'd50);
        bus_write(1, mkc(8'hFF, 3, 0, 0, 0, 0, 1, 0));
        for (int i = 0; i < 2000; i++) begin bus_read(2, d); if (d[15]) break; end
        bus_write(1, mkc(8'hFF, 3, 0, 0, 0, 0, 0, 0));
        idle(100);
        bus_read(2, d); chk(d == 16'h8040, "R7 full and flagged", d, 16'h8040);
        check_stream(3, 8'hFF, 64, "R7 oldest kept");
        bus_read(2, d); chk(d == 16'h8000, "R7 flag sticky", d, 16'h8000);
        prep();
        bus_read(2, d); chk(d == 16'h0000, "R8 wipe clears", d, 0);

        // R9 level interrupt
        prep(); set_period(32'd200); bus_write(6, 16'd4);
        bus_write(1, mkc(8'h03, 0, 0, 0, 0, 1, 1, 0));
        mism = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); bus_addr = 3'd2; bus_rd = 1'b1; #1 d = bus_rdata;
            if (irq != (d[14:0] >= 15'd4)) mism++;
            @(negedge clk); bus_rd = 1'b0;
            if (d[14:0] >= 15'd6) break;
        end
        chk(mism == 0, "R9 level tracks count", mism, 0);
        bus_write(1, mkc(8'h03, 0, 0, 0, 0, 1, 0, 0));
        idle(40);
        bus_read(2, d); n = int'(d[14:0]);
        chk(irq == 1'b1, "R9 above threshold", irq, 1);
        for (int i = 0; i < n - 3; i++) bus_read(3, d);
        bus_read(2, d);
        chk(d[14:0] == 15'd3 && irq == 1'b0, "R9 below after pops", {d[14:0], irq}, 6);

        // R10 edge interrupt
        prep(); set_period(32'd80); bus_write(6, 16'd4);
        irq_hits = 0; cnt_irq = 1;
        bus_write(1, mkc(8'h03, 0, 0, 0, 1, 1, 1, 0));
        wait_count(6, n);
        bus_write(1, mkc(8'h03, 0, 0, 0, 1, 1, 0, 0));
        idle(100); cnt_irq = 0;
        chk(irq_hits == 1, "R10 single pulse", irq_hits, 1);
        chk(irq == 1'b0, "R10 low after pulse", irq, 0);

        // R11 hold asleep
        prep(); set_period(32'd20);
        bus_write(1, mkc(8'hFF, 3, 1, 0, 0, 0, 1, 0));
        s0 = starts; idle(200);
        chk(starts == s0, "R11 no start", starts - s0, 0);
        chk(conv_standby == 4'hF, "R11 standby high", conv_standby, 4'hF);

        // R12 sleep between frames
        prep(); set_period(32'd100); sb_bad = 0;
        bus_write(1, mkc(8'h01, 0, 0, 1, 0, 0, 1, 0));
        wait_count(1, n); idle(10);
        chk(conv_standby == 4'hF, "R12 asleep while idle", conv_standby, 4'hF);
        s0 = starts;
        for (int i = 0; i < 400 && starts == s0; i++) @(negedge clk);
        chk(sb_bad == 0 && conv_standby == 4'h0, "R12 awake during frame", conv_standby, 0);
        bus_write(1, mkc(8'h01, 0, 0, 0, 0, 0, 0, 0));
        idle(60);
        chk(conv_standby == 4'h0, "R12 awake without sleep bit", conv_standby, 0);

        fin = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule